// File: doc/BRIEF.md
# Two-Dimensional Parity Error Locator

This block watches a stream of bytes that arrive in frames. Each data byte holds a 7-bit character in bits 6..0. Bit 7 is a parity bit, chosen so that the whole byte has an odd number of ones. After the data bytes comes one more byte, the block-check byte. Each of its bits is a parity bit for one bit column, taken over all the data bytes.

While the frame streams in, the block tests the parity of every data byte. It also keeps a running XOR of every bit column. When the block-check byte arrives, the block compares the column totals against it. One cycle later it reports whether the frame held an error. For a single flipped bit it also reports which byte holds the error, which bit position was flipped, and what the byte should have been. If the errors cannot be resolved to one bit, the block raises a separate flag.

The block sits at the receiving end of a link. An upstream stage pushes bytes, one per cycle, whenever it has one. A downstream consumer waits for the done pulse and then reads the registered result. The result stays valid until the next frame ends. The block does not store the frame, so any correction has to be applied by whoever kept the data.

Top module: `par2d_locator`

## Requirements
- R1: After reset, `done_o`, `err_flag_o`, `multi_err_o`, `err_byte_o`, `err_bit_o` and `corr_byte_o` are all 0.
- R2: A byte is accepted on each rising clock edge where `in_valid_i` is 1. When an accepted byte has `in_last_i` set, `done_o` is 1 for exactly one cycle after that edge. All result outputs then hold their values until the next `done_o`.
- R3: A data byte passes its row check when all 8 of its bits together hold an odd number of ones. Bit 7 is the parity bit. When exactly one data byte fails its row check and exactly one column fails, `err_byte_o` gives that byte's zero-based position in the frame.
- R4: Column parity is odd by default. Summed over all data bytes plus the block-check byte, each of the 8 bit columns must hold an odd number of ones. When a single error is located, `err_bit_o` is the failing column, from 0 (LSB) to 7 (the parity bit).
- R5: If exactly one column fails and no data byte fails its row check, the error is in the block-check byte. In that case `err_flag_o` is 1, `multi_err_o` is 0, and `err_byte_o` equals DATA_BYTES (11 by default).
- R6: For a located single error, `corr_byte_o` is the received faulty byte with bit `err_bit_o` inverted.
- R7: `multi_err_o` is 1, together with `err_flag_o`, in any of these cases: more than one row fails, more than one column fails, or a row fails while no column fails.
- R8: A frame with no failing row and no failing column reports 0 on `err_flag_o`, `multi_err_o`, `err_byte_o`, `err_bit_o` and `corr_byte_o`.
- R9: Cycles with `in_valid_i` at 0 are ignored, whatever is on `in_data_i` and `in_last_i`. Byte positions count accepted bytes only.
- R10: The first byte accepted after a frame end starts a fresh frame. Row and column state from earlier frames does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte on `in_data_i` is valid this cycle |
| in_data_i | input | 8 | Received byte |
| in_last_i | input | 1 | This byte is the block-check byte |
| done_o | output | 1 | One-cycle pulse: result updated |
| err_flag_o | output | 1 | Frame contained a parity error |
| multi_err_o | output | 1 | Error pattern cannot be resolved to one bit |
| err_byte_o | output | $clog2(DATA_BYTES+1) | Position of the faulty byte; DATA_BYTES means the block-check byte |
| err_bit_o | output | 3 | Position of the flipped bit |
| corr_byte_o | output | 8 | Faulty byte with the located bit inverted |

## Verification
The bench sends an 11-character text frame in four kinds of versions:
- **Clean:** a clean frame shows that a valid frame raises no flags, and again after errored frames that no state carries over.
- **Single flips:** single bit flips at the first and last data byte, at the parity bit and at bit 0, and inside the block-check byte. These separate the row-locating path from the column-locating path and from the check-byte case.
- **Paired flips:** two flips in one byte, two flips in one column, and a data flip paired with the same column flipped in the check byte. Each of these triggers a different condition of the multi-error rule.
- **Idle gaps:** some frames carry idle cycles with junk on the inputs between bytes. Their results must match those of gap-free frames.

// File: rtl/par2d_pkg.sv
package par2d_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  // saturating classification of how many checks failed
  typedef enum logic [1:0] {
    FAIL_NONE = 2'd0,
    FAIL_ONE  = 2'd1,
    FAIL_MANY = 2'd2
  } fail_cls_e;

  typedef struct packed {
    logic             err;
    logic             multi;
    logic [BIT_W-1:0] bit_idx;
    byte_t            corr;
  } res_t;

  function automatic fail_cls_e classify(input byte_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < BYTE_W; i++) n += int'(v[i]);
    if (n == 0)      return FAIL_NONE;
    else if (n == 1) return FAIL_ONE;
    else             return FAIL_MANY;
  endfunction

  function automatic logic [BIT_W-1:0] lowest_set(input byte_t v);
    logic [BIT_W-1:0] pos;
    pos = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) if (v[i]) pos = BIT_W'(i);
    return pos;
  endfunction
endpackage

// File: rtl/par2d_row_check.sv
module par2d_row_check
  import par2d_pkg::*;
#(
  parameter bit ROW_ODD = 1'b1
) (
  input  byte_t data_i,
  output logic  bad_o
);
  logic xor_all;
  assign xor_all = ^data_i;

  generate
    if (ROW_ODD) begin : g_odd
      assign bad_o = ~xor_all;
    end else begin : g_even
      assign bad_o = xor_all;
    end
  endgenerate
endmodule

// File: rtl/par2d_col_accum.sv
module par2d_col_accum
  import par2d_pkg::*;
#(
  parameter bit COL_ODD = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  data_en_i,
  input  byte_t data_i,
  input  byte_t check_i,
  output byte_t syndrome_o
);
  byte_t acc_q, acc_base, total;

  // a new frame discards the previous totals without a dead cycle
  assign acc_base = start_i ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (data_en_i) acc_q <= acc_base ^ data_i;
  end

  assign total = acc_base ^ check_i;

  generate
    if (COL_ODD) begin : g_odd
      assign syndrome_o = ~total;
    end else begin : g_even
      assign syndrome_o = total;
    end
  endgenerate
endmodule

// File: rtl/par2d_row_track.sv
module par2d_row_track
  import par2d_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             data_en_i,
  input  logic             row_bad_i,
  input  byte_t            data_i,
  output fail_cls_e        fails_o,
  output logic [IDX_W-1:0] fail_idx_o,
  output byte_t            fail_byte_o
);
  logic [IDX_W-1:0] cnt_q, cur_idx;
  logic [IDX_W-1:0] idx_q;
  byte_t            byte_q;
  fail_cls_e        fails_q, fails_base;

  assign cur_idx    = start_i ? '0 : cnt_q;
  assign fails_base = start_i ? FAIL_NONE : fails_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      byte_q  <= '0;
      fails_q <= FAIL_NONE;
    end else if (data_en_i) begin
      if (cur_idx != '1) cnt_q <= cur_idx + 1'b1;
      else               cnt_q <= cur_idx;
      if (row_bad_i) begin
        if (fails_base == FAIL_NONE) begin
          fails_q <= FAIL_ONE;
          idx_q   <= cur_idx;
          byte_q  <= data_i;
        end else begin
          fails_q <= FAIL_MANY;
        end
      end else begin
        fails_q <= fails_base;
      end
    end
  end

  assign fails_o     = fails_base;
  assign fail_idx_o  = idx_q;
  assign fail_byte_o = byte_q;
endmodule

// File: rtl/par2d_resolve.sv
module par2d_resolve
  import par2d_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 11,
  parameter int unsigned IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_end_i,
  input  fail_cls_e        row_fails_i,
  input  logic [IDX_W-1:0] row_idx_i,
  input  byte_t            row_byte_i,
  input  byte_t            syndrome_i,
  input  byte_t            check_i,
  output logic             done_o,
  output res_t             res_o,
  output logic [IDX_W-1:0] byte_idx_o
);
  fail_cls_e        col_cls;
  logic [BIT_W-1:0] col_pos;
  byte_t            flip_mask;
  res_t             res_d, res_q;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             done_q;

  assign col_cls   = classify(syndrome_i);
  assign col_pos   = lowest_set(syndrome_i);
  assign flip_mask = byte_t'(1) << col_pos;

  always_comb begin
    res_d = '0;
    idx_d = '0;
    if (row_fails_i == FAIL_NONE && col_cls == FAIL_NONE) begin
      res_d = '0;
    end else if (row_fails_i == FAIL_ONE && col_cls == FAIL_ONE) begin
      res_d.err     = 1'b1;
      res_d.bit_idx = col_pos;
      res_d.corr    = row_byte_i ^ flip_mask;
      idx_d         = row_idx_i;
    end else if (row_fails_i == FAIL_NONE && col_cls == FAIL_ONE) begin
      // only the check byte itself can produce this pattern
      res_d.err     = 1'b1;
      res_d.bit_idx = col_pos;
      res_d.corr    = check_i ^ flip_mask;
      idx_d         = IDX_W'(DATA_BYTES);
    end else begin
      res_d.err   = 1'b1;
      res_d.multi = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
      idx_q  <= '0;
    end else begin
      done_q <= frame_end_i;
      if (frame_end_i) begin
        res_q <= res_d;
        idx_q <= idx_d;
      end
    end
  end

  assign done_o     = done_q;
  assign res_o      = res_q;
  assign byte_idx_o = idx_q;
endmodule

// File: rtl/par2d_locator.sv
module par2d_locator
  import par2d_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 11,
  parameter bit          ROW_ODD    = 1'b1,
  parameter bit          COL_ODD    = 1'b1,
  localparam int unsigned IDX_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  output logic             done_o,
  output logic             err_flag_o,
  output logic             multi_err_o,
  output logic [IDX_W-1:0] err_byte_o,
  output logic [2:0]       err_bit_o,
  output logic [7:0]       corr_byte_o
);
  logic             in_frame_q, start, data_en, frame_end, row_bad;
  fail_cls_e        row_fails;
  logic [IDX_W-1:0] row_idx;
  byte_t            row_byte, syndrome;
  res_t             res;

  assign data_en   = in_valid_i & ~in_last_i;
  assign frame_end = in_valid_i & in_last_i;
  assign start     = in_valid_i & ~in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        in_frame_q <= 1'b0;
    else if (in_valid_i) in_frame_q <= ~in_last_i;
  end

  par2d_row_check #(.ROW_ODD(ROW_ODD)) u_row_check (
    .data_i (in_data_i),
    .bad_o  (row_bad)
  );

  par2d_row_track #(.IDX_W(IDX_W)) u_row_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .data_en_i   (data_en),
    .row_bad_i   (row_bad),
    .data_i      (in_data_i),
    .fails_o     (row_fails),
    .fail_idx_o  (row_idx),
    .fail_byte_o (row_byte)
  );

  par2d_col_accum #(.COL_ODD(COL_ODD)) u_col_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .data_en_i  (data_en),
    .data_i     (in_data_i),
    .check_i    (in_data_i),
    .syndrome_o (syndrome)
  );

  par2d_resolve #(.DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W)) u_resolve (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end),
    .row_fails_i (row_fails),
    .row_idx_i   (row_idx),
    .row_byte_i  (row_byte),
    .syndrome_i  (syndrome),
    .check_i     (in_data_i),
    .done_o      (done_o),
    .res_o       (res),
    .byte_idx_o  (err_byte_o)
  );

  assign err_flag_o  = res.err;
  assign multi_err_o = res.multi;
  assign err_bit_o   = res.bit_idx;
  assign corr_byte_o = res.corr;
endmodule

// File: rtl/par2d_locator_chk.sv
module par2d_locator_chk #(
  parameter int unsigned DATA_BYTES = 11,
  parameter int unsigned IDX_W      = 4,
  parameter bit          ROW_ODD    = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_last_i,
  input logic             done_o,
  input logic             err_flag_o,
  input logic             multi_err_o,
  input logic [IDX_W-1:0] err_byte_o,
  input logic [2:0]       err_bit_o,
  input logic [7:0]       corr_byte_o
);
  assert_done_after_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(in_valid_i && in_last_i));

  assert_result_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(err_flag_o) && $stable(multi_err_o) && $stable(err_byte_o)
                 && $stable(err_bit_o) && $stable(corr_byte_o)));

  assert_multi_has_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_err_o |-> err_flag_o);

  assert_clean_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_flag_o |-> (err_byte_o == '0 && err_bit_o == '0 && corr_byte_o == '0));

  assert_index_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !multi_err_o) |-> (int'(err_byte_o) <= int'(DATA_BYTES)));

  assert_corrected_row_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_flag_o && !multi_err_o && int'(err_byte_o) < int'(DATA_BYTES))
      |-> ((^corr_byte_o) == ROW_ODD));
endmodule

bind par2d_locator par2d_locator_chk #(
  .DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W), .ROW_ODD(ROW_ODD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_last_i   (in_last_i),
  .done_o      (done_o),
  .err_flag_o  (err_flag_o),
  .multi_err_o (multi_err_o),
  .err_byte_o  (err_byte_o),
  .err_bit_o   (err_bit_o),
  .corr_byte_o (corr_byte_o)
);

// File: tb/par2d_locator_tb.sv
module par2d_locator_tb;
  localparam int N     = 11;
  localparam int IDX_W = $clog2(N + 1);

  typedef logic [7:0] frame_t [N+1];
  typedef struct {
    bit         err;
    bit         multi;
    int         byte_i;
    int         bit_i;
    logic [7:0] corr;
    string      ctx;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [7:0]       in_data_i = '0;
  logic             in_last_i = 1'b0;
  logic             done_o, err_flag_o, multi_err_o;
  logic [IDX_W-1:0] err_byte_o;
  logic [2:0]       err_bit_o;
  logic [7:0]       corr_byte_o;

  int n_chk = 0, n_fail = 0, n_done = 0, n_sent = 0;
  exp_t   exp_q[$];
  frame_t good;

  always #5 clk_i = ~clk_i;

  par2d_locator #(.DATA_BYTES(N)) u_dut (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_last_i,
    .done_o, .err_flag_o, .multi_err_o, .err_byte_o, .err_bit_o, .corr_byte_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // odd row parity in bit 7, odd column parity in the check byte
  function automatic frame_t build_good();
    frame_t f;
    string  msg = "LOGIC GATES";
    logic [7:0] col;
    col = '0;
    for (int i = 0; i < N; i++) begin
      logic [6:0] c;
      c = msg[i][6:0];
      f[i] = {~^c, c};
      col ^= f[i];
    end
    f[N] = ~col;
    return f;
  endfunction

  task automatic send_frame(input frame_t f, input bit gaps);
    for (int i = 0; i <= N; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk_i);
        in_valid_i = 1'b0; in_data_i = 8'hA5; in_last_i = 1'b1;
        @(negedge clk_i);
        in_data_i = 8'h3C; in_last_i = 1'b0;
      end
      @(negedge clk_i);
      in_valid_i = 1'b1; in_data_i = f[i]; in_last_i = (i == N);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0; in_last_i = 1'b0; in_data_i = '0;
    n_sent++;
  endtask

  task automatic run_clean(input string ctx, input bit gaps);
    exp_q.push_back('{0, 0, 0, 0, 8'h00, ctx});
    send_frame(good, gaps);
  endtask

  task automatic run_single(input int bi, input int bb, input bit gaps, input string ctx);
    frame_t f;
    f = good;
    f[bi][bb] = ~f[bi][bb];
    exp_q.push_back('{1, 0, bi, bb, good[bi], ctx});
    send_frame(f, gaps);
  endtask

  task automatic run_double(input int b1, input int t1, input int b2, input int t2, input string ctx);
    frame_t f;
    f = good;
    f[b1][t1] = ~f[b1][t1];
    f[b2][t2] = ~f[b2][t2];
    exp_q.push_back('{1, 1, 0, 0, 8'h00, ctx});
    send_frame(f, 1'b0);
  endtask

  // monitor: compare each result, then confirm pulse width and hold
  initial begin
    exp_t e;
    logic [IDX_W-1:0] hb;
    logic [7:0] hc;
    bit hold_pending;
    hold_pending = 0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && hold_pending && !done_o) begin
        chk("R2", "held err_byte", int'(err_byte_o), int'(hb));
        chk("R2", "held corr", int'(corr_byte_o), int'(hc));
        hold_pending = 0;
      end
      if (rst_ni && done_o) begin
        n_done++;
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(e.ctx, "err_flag", int'(err_flag_o), int'(e.err));
          chk(e.multi ? "R7" : e.ctx, "multi_err", int'(multi_err_o), int'(e.multi));
          if (e.err && !e.multi) begin
            chk(e.byte_i == N ? "R5" : "R3", "err_byte", int'(err_byte_o), e.byte_i);
            chk("R4", "err_bit", int'(err_bit_o), e.bit_i);
            chk("R6", "corr_byte", int'(corr_byte_o), int'(e.corr));
          end else if (!e.err) begin
            chk("R8", "err_byte", int'(err_byte_o), 0);
            chk("R8", "corr_byte", int'(corr_byte_o), 0);
          end
          hb = err_byte_o; hc = corr_byte_o; hold_pending = 1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    chk("R2", "watchdog frames finished", n_done, n_sent + 1000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    good = build_good();
    repeat (3) @(negedge clk_i);
    chk("R1", "done after reset", int'(done_o), 0);
    chk("R1", "err_flag after reset", int'(err_flag_o), 0);
    chk("R1", "multi after reset", int'(multi_err_o), 0);
    chk("R1", "corr after reset", int'(corr_byte_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "done idle", int'(done_o), 0);

    run_clean("R8 clean", 1'b0);
    run_single(0, 7, 1'b0, "R3 first byte parity bit");
    run_single(N - 1, 0, 1'b0, "R3 last byte bit0");
    run_single(5, 3, 1'b0, "R3 mid byte");
    run_single(N, 7, 1'b0, "R5 check byte bit7");
    run_single(N, 2, 1'b0, "R5 check byte bit2");
    run_double(4, 1, 4, 6, "R7 two cols one byte");
    run_double(2, 5, 8, 5, "R7 two rows one col");
    run_double(6, 4, N, 4, "R7 row without col");
    run_double(1, 0, 9, 3, "R7 two rows two cols");
    run_clean("R10 after errors", 1'b0);
    run_single(7, 6, 1'b1, "R9 gaps data byte");
    run_single(N, 0, 1'b1, "R9 gaps check byte");
    run_clean("R9 gaps clean", 1'b1);
    run_single(3, 1, 1'b0, "R10 fresh frame");

    repeat (4) @(negedge clk_i);
    chk("R2", "done pulses vs frames", n_done, n_sent);
    chk("R2", "scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule